// File: doc/BRIEF.md
# SDRAM Power-Up and Mode Register Sequencer

This block brings an SDRAM from reset into a usable state. Once reset is released it holds the command bus at NOP for a programmable power-up interval. It then precharges every bank and issues a configurable number of auto-refresh commands. Next it writes the standard mode register and then the extended mode register, using values built from its configuration inputs. When that write has settled it raises `init_done`.

After initialization, the memory controller can ask the block to rewrite the standard register, the extended register or both. The block acts on such a request only when it is idle and the controller reports that every bank is idle. It handles only the command and address pins and leaves the data bus, periodic refresh and bursts to other logic.

Command timing comes from parameters. `PWRUP_CYC` sets the power-up wait. `T_RP` sets the precharge-to-refresh spacing, `T_RFC` the spacing between refreshes and `T_MRD` the spacing after a mode write, all in clocks. `NUM_REF` sets the number of warm-up refreshes and defaults to 2. Every clock with no command carries a NOP.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst` is high, the outputs settle one clock later to: NOP ({cs_n,ras_n,cas_n,we_n}=0111), `addr`=0, `ba`=0, `init_done`=0 and `busy`=1.
- R2: For the first `PWRUP_CYC` clocks after reset release only NOP is driven. The first command is then a precharge-all, encoded as 0010 with `addr[10]`=1.
- R3: After the precharge come exactly `NUM_REF` auto-refresh commands (0001). The first refresh follows the precharge by exactly `T_RP` clocks, and each later refresh, as well as the standard mode write, follows the previous refresh by exactly `T_RFC` clocks.
- R4: A standard mode write is encoded as 0000 with `ba`=00. Its address bits are: `addr[2:0]` = burst length code (000=1, 001=2, 010=4, 011=8, 111=full page), `addr[3]` = 1 for interleaved order, and `addr[6:4]` = 010 for CAS latency 2 or 011 for latency 3 (`cfg_cl3`). All higher address bits are zero.
- R5: An extended mode write is encoded as 0000 with `ba`=10. Its address bits are: `addr[2:0]` = partial-array refresh code (000 = all four banks, 001 = two banks), `addr[4:3]` = temperature-compensation code and `addr[6:5]` = drive-strength code. All higher address bits are zero.
- R6: During initialization the extended write comes exactly `T_MRD` clocks after the standard write. `init_done` rises exactly `T_MRD` clocks after the extended write, and the clock after any mode write carries a NOP.
- R7: Every clock carries one of NOP, precharge-all, refresh or a mode write, and no other code.
- R8: When `init_done`=1, `busy`=0 and `banks_idle`=1 at a clock edge, a single-register request is accepted. The matching mode write appears on the pins two clocks after the request is presented, and `busy` is high in that clock.
- R9: If `req_std` and `req_ext` are accepted together, the standard write is issued first and the extended write follows exactly `T_MRD` clocks later.
- R10: A request made while `banks_idle`=0, or before `init_done` is high, is dropped. No extra command appears and the initialization sequence is unchanged.
- R11: Once `init_done` rises it stays high until reset, and while `busy`=0 the bus carries only NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cl3 | input | 1 | 1 selects CAS latency 3, 0 selects 2 |
| cfg_burst_len | input | 3 | Burst length code |
| cfg_interleave | input | 1 | 1 selects interleaved burst order |
| cfg_pasr | input | 3 | Partial-array refresh code |
| cfg_tcsr | input | 2 | Temperature-compensated refresh code |
| cfg_drive | input | 2 | Output drive-strength code |
| req_std | input | 1 | Request to rewrite the standard mode register |
| req_ext | input | 1 | Request to rewrite the extended mode register |
| banks_idle | input | 1 | All banks are precharged and idle |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address (selects the mode register) |
| addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Initialization complete |
| busy | output | 1 | Sequencer is running a command sequence |

## Verification
The bench records every command with its clock index. It targets off-by-one errors in the waits. A design that counts one clock short would put the first refresh `T_RP-1` clocks after the precharge, or raise `init_done` one clock early. Configuration vectors cover every address field, including the full-page length code and the two-bank refresh code, so a swapped or misplaced field shows up as a wrong mode word. The reprogram tests check three things. A request with both registers must issue two writes in the right order. A request made while banks are active, or during initialization, must leave the bus at NOP. A design that latched such a request would issue a stray mode write later.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {K_NOP, K_PRE, K_REF, K_MRS, K_EMR} cmd_kind_t;

  typedef enum logic [2:0] {
    ST_PWR, ST_PRE, ST_REF, ST_MRS, ST_EMR, ST_WAIT, ST_IDLE
  } seq_state_t;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] PIN_NOP = 4'b0111;
  localparam logic [3:0] PIN_PRE = 4'b0010;
  localparam logic [3:0] PIN_REF = 4'b0001;
  localparam logic [3:0] PIN_MRS = 4'b0000;

  localparam logic [1:0] BA_STD = 2'b00;
  localparam logic [1:0] BA_EXT = 2'b10;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Standard word: [6:4] latency, [3] order, [2:0] length
  function automatic logic [6:0] std_word(input logic cl3, input logic [2:0] blen,
                                          input logic ilv);
    return {2'b01, cl3, ilv, blen};
  endfunction

  // Extended word: [6:5] drive, [4:3] temperature, [2:0] array part
  function automatic logic [6:0] ext_word(input logic [2:0] pasr, input logic [1:0] tcsr,
                                          input logic [1:0] drv);
    return {drv, tcsr, pasr};
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= RST_VAL;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - W'(1);
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int NUM_REF = 2,
  parameter int T_RP    = 2,
  parameter int T_RFC   = 4,
  parameter int T_MRD   = 2,
  parameter int TW      = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          zero,
  input  logic          req_std,
  input  logic          req_ext,
  input  logic          banks_idle,
  output cmd_kind_t     kind,
  output logic          load,
  output logic [TW-1:0] load_val,
  output logic          idle_st,
  output logic          inited
);

  localparam int RW = $clog2(NUM_REF + 1);

  seq_state_t    state_q, after_q;
  logic [RW-1:0] ref_left_q;
  logic          pend_std_q, pend_ext_q;
  logic          inited_q;

  always_comb begin
    kind     = K_NOP;
    load     = 1'b0;
    load_val = '0;
    unique case (state_q)
      ST_PRE: begin kind = K_PRE; load = 1'b1; load_val = TW'(T_RP - 2);  end
      ST_REF: begin kind = K_REF; load = 1'b1; load_val = TW'(T_RFC - 2); end
      ST_MRS: begin kind = K_MRS; load = 1'b1; load_val = TW'(T_MRD - 2); end
      ST_EMR: begin kind = K_EMR; load = 1'b1; load_val = TW'(T_MRD - 2); end
      default: ;
    endcase
  end

  assign idle_st = (state_q == ST_IDLE);
  assign inited  = inited_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_PWR;
      after_q    <= ST_PRE;
      ref_left_q <= RW'(NUM_REF);
      pend_std_q <= 1'b1;
      pend_ext_q <= 1'b1;
      inited_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_PWR:  if (zero) state_q <= ST_PRE;
        ST_PRE: begin
          state_q <= ST_WAIT;
          after_q <= ST_REF;
        end
        ST_REF: begin
          state_q    <= ST_WAIT;
          ref_left_q <= ref_left_q - RW'(1);
          if (ref_left_q == RW'(1)) after_q <= pend_std_q ? ST_MRS : ST_EMR;
          else                      after_q <= ST_REF;
        end
        ST_MRS: begin
          state_q <= ST_WAIT;
          after_q <= pend_ext_q ? ST_EMR : ST_IDLE;
        end
        ST_EMR: begin
          state_q <= ST_WAIT;
          after_q <= ST_IDLE;
        end
        ST_WAIT: if (zero) state_q <= after_q;
        ST_IDLE: begin
          inited_q <= 1'b1;
          if (inited_q && banks_idle && (req_std || req_ext)) begin
            pend_std_q <= req_std;
            pend_ext_q <= req_ext;
            state_q    <= req_std ? ST_MRS : ST_EMR;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sdram_init_drive.sv
module sdram_init_drive
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  cmd_kind_t         kind,
  input  logic              idle_st,
  input  logic              cfg_cl3,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_interleave,
  input  logic [2:0]        cfg_pasr,
  input  logic [1:0]        cfg_tcsr,
  input  logic [1:0]        cfg_drive,
  output logic [3:0]        pins,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              busy
);

  logic [3:0]        pins_d;
  logic [1:0]        ba_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    pins_d = PIN_NOP;
    ba_d   = '0;
    addr_d = '0;
    unique case (kind)
      K_PRE: begin pins_d = PIN_PRE; addr_d[10] = 1'b1; end
      K_REF: pins_d = PIN_REF;
      K_MRS: begin
        pins_d      = PIN_MRS;
        ba_d        = BA_STD;
        addr_d[6:0] = std_word(cfg_cl3, cfg_burst_len, cfg_interleave);
      end
      K_EMR: begin
        pins_d      = PIN_MRS;
        ba_d        = BA_EXT;
        addr_d[6:0] = ext_word(cfg_pasr, cfg_tcsr, cfg_drive);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pins <= PIN_NOP;
      ba   <= '0;
      addr <= '0;
      busy <= 1'b1;
    end else begin
      pins <= pins_d;
      ba   <= ba_d;
      addr <= addr_d;
      busy <= ~idle_st;
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int PWRUP_CYC = 100,
  parameter int NUM_REF   = 2,
  parameter int T_RP      = 2,
  parameter int T_RFC     = 4,
  parameter int T_MRD     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_cl3,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_interleave,
  input  logic [2:0]        cfg_pasr,
  input  logic [1:0]        cfg_tcsr,
  input  logic [1:0]        cfg_drive,
  input  logic              req_std,
  input  logic              req_ext,
  input  logic              banks_idle,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done,
  output logic              busy
);

  localparam int MAXT = imax(imax(PWRUP_CYC, T_RP), imax(T_RFC, T_MRD));
  localparam int TW   = $clog2(MAXT + 1);

  cmd_kind_t     kind;
  logic          load, zero, idle_st;
  logic [TW-1:0] load_val;
  logic [3:0]    pins;

  sdram_init_timer #(.W(TW), .RST_VAL(TW'(PWRUP_CYC - 1))) u_timer (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .zero(zero)
  );

  sdram_init_fsm #(
    .NUM_REF(NUM_REF), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD), .TW(TW)
  ) u_fsm (
    .clk(clk), .rst(rst), .zero(zero), .req_std(req_std), .req_ext(req_ext),
    .banks_idle(banks_idle), .kind(kind), .load(load), .load_val(load_val),
    .idle_st(idle_st), .inited(init_done)
  );

  sdram_init_drive #(.ADDR_W(ADDR_W)) u_drive (
    .clk(clk), .rst(rst), .kind(kind), .idle_st(idle_st),
    .cfg_cl3(cfg_cl3), .cfg_burst_len(cfg_burst_len), .cfg_interleave(cfg_interleave),
    .cfg_pasr(cfg_pasr), .cfg_tcsr(cfg_tcsr), .cfg_drive(cfg_drive),
    .pins(pins), .ba(ba), .addr(addr), .busy(busy)
  );

  assign {cs_n, ras_n, cas_n, we_n} = pins;

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [1:0]        ba,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done,
  input logic              busy
);

  logic [3:0] pin;
  logic is_nop, is_pre, is_ref, is_mrs;
  assign pin    = {cs_n, ras_n, cas_n, we_n};
  assign is_nop = (pin == 4'b0111);
  assign is_pre = (pin == 4'b0010);
  assign is_ref = (pin == 4'b0001);
  assign is_mrs = (pin == 4'b0000);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (is_nop && !init_done && busy && addr == '0));

  // R2
  pre_all_chk: assert property (@(posedge clk) disable iff (rst)
    is_pre |-> addr[10]);

  // R4
  mrs_upper_chk: assert property (@(posedge clk) disable iff (rst)
    is_mrs |-> (addr[ADDR_W-1:7] == '0 && (ba == 2'b00 || ba == 2'b10)));

  // R6
  mrs_gap_chk: assert property (@(posedge clk) disable iff (rst)
    is_mrs |=> is_nop);

  // R7
  cmd_legal_chk: assert property (@(posedge clk) disable iff (rst)
    is_nop || is_pre || is_ref || is_mrs);

  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  // R11
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> is_nop);

endmodule

bind sdram_init_seq sdram_init_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .ba(ba), .addr(addr), .init_done(init_done), .busy(busy)
);

// File: tb/sdram_init_seq_test.sv
module sdram_init_seq_test;

  localparam int AW  = 12;
  localparam int PW  = 30;
  localparam int NR  = 3;
  localparam int TRP = 3;
  localparam int TRF = 5;
  localparam int TMR = 2;

  // {cl3, blen[3], ilv, pasr[3], tcsr[2], drv[2], exp_std[7], exp_ext[7]}
  localparam logic [25:0] VEC [4] = '{
    {1'b1, 3'b011, 1'b0, 3'b000, 2'b00, 2'b01, 7'b0110011, 7'b0100000},
    {1'b0, 3'b000, 1'b1, 3'b001, 2'b10, 2'b00, 7'b0101000, 7'b0010001},
    {1'b1, 3'b111, 1'b0, 3'b010, 2'b01, 2'b11, 7'b0110111, 7'b1101010},
    {1'b0, 3'b010, 1'b1, 3'b101, 2'b11, 2'b10, 7'b0101010, 7'b1011101}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_cl3 = 1'b0, cfg_interleave = 1'b0;
  logic [2:0] cfg_burst_len = '0, cfg_pasr = '0;
  logic [1:0] cfg_tcsr = '0, cfg_drive = '0;
  logic req_std = 1'b0, req_ext = 1'b0, banks_idle = 1'b1;
  logic cs_n, ras_n, cas_n, we_n, init_done, busy;
  logic [1:0] ba;
  logic [AW-1:0] addr;

  always #4 clk = ~clk;

  sdram_init_seq #(.ADDR_W(AW), .PWRUP_CYC(PW), .NUM_REF(NR), .T_RP(TRP),
                   .T_RFC(TRF), .T_MRD(TMR)) uut (
    .clk(clk), .rst(rst), .cfg_cl3(cfg_cl3), .cfg_burst_len(cfg_burst_len),
    .cfg_interleave(cfg_interleave), .cfg_pasr(cfg_pasr), .cfg_tcsr(cfg_tcsr),
    .cfg_drive(cfg_drive), .req_std(req_std), .req_ext(req_ext),
    .banks_idle(banks_idle), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .init_done(init_done), .busy(busy)
  );

  int checks = 0, errors = 0;
  // event codes: 1 precharge, 2 refresh, 3 std write, 4 ext write, 7 illegal
  int ev_k [16];
  int ev_t [16];
  logic [AW-1:0] ev_a [16];
  int n_ev, done_k, pulse_k, busy_at2;
  bit done_dropped;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int decode();
    case ({cs_n, ras_n, cas_n, we_n})
      4'b0111: return 0;
      4'b0010: return 1;
      4'b0001: return 2;
      4'b0000: return (ba == 2'b10) ? 4 : 3;
      default: return 7;
    endcase
  endfunction

  task automatic run(input int n, input bit stop_on_done);
    n_ev = 0; done_k = -1; busy_at2 = -1; done_dropped = 0;
    for (int k = 1; k <= n; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 1 || k == pulse_k + 1) begin req_std = 1'b0; req_ext = 1'b0; end
      if (k == pulse_k) begin req_std = 1'b1; req_ext = 1'b1; end
      if (k == 2) busy_at2 = busy;
      if (!stop_on_done && !init_done) done_dropped = 1;
      if (decode() != 0 && n_ev < 16) begin
        ev_k[n_ev] = k; ev_t[n_ev] = decode(); ev_a[n_ev] = addr; n_ev++;
      end
      if (stop_on_done && init_done) begin done_k = k; break; end
    end
  endtask

  task automatic set_cfg(input logic [25:0] v);
    cfg_cl3 = v[25]; cfg_burst_len = v[24:22]; cfg_interleave = v[21];
    cfg_pasr = v[20:18]; cfg_tcsr = v[17:16]; cfg_drive = v[15:14];
  endtask

  task automatic do_init();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1 cmd", {cs_n, ras_n, cas_n, we_n}, 7);
    chk(addr == '0 && ba == '0, "R1 addr", addr, 0);
    chk(init_done == 1'b0, "R1 done", init_done, 0);
    chk(busy == 1'b1, "R1 busy", busy, 1);
    rst = 1'b0;
    run(1000, 1'b1);
  endtask

  task automatic verify_seq(input logic [6:0] es, input logic [6:0] ee);
    chk(n_ev == NR + 3, "R3 count", n_ev, NR + 3);
    chk(ev_t[0] == 1, "R2 first", ev_t[0], 1);
    chk(ev_k[0] > PW, "R2 powerup", ev_k[0], PW + 1);
    chk(ev_a[0][10] == 1'b1, "R2 a10", ev_a[0][10], 1);
    chk(ev_k[1] - ev_k[0] == TRP, "R3 trp", ev_k[1] - ev_k[0], TRP);
    for (int i = 1; i <= NR; i++) begin
      chk(ev_t[i] == 2, "R3 ref", ev_t[i], 2);
      chk(ev_k[i + 1] - ev_k[i] == TRF, "R3 trfc", ev_k[i + 1] - ev_k[i], TRF);
    end
    chk(ev_t[NR + 1] == 3, "R4 kind", ev_t[NR + 1], 3);
    chk(ev_a[NR + 1] == {{(AW - 7){1'b0}}, es}, "R4 word", ev_a[NR + 1], es);
    chk(ev_t[NR + 2] == 4, "R5 kind", ev_t[NR + 2], 4);
    chk(ev_a[NR + 2] == {{(AW - 7){1'b0}}, ee}, "R5 word", ev_a[NR + 2], ee);
    chk(ev_k[NR + 2] - ev_k[NR + 1] == TMR, "R6 gap", ev_k[NR + 2] - ev_k[NR + 1], TMR);
    chk(done_k - ev_k[NR + 2] == TMR, "R6 done", done_k - ev_k[NR + 2], TMR);
  endtask

  task automatic reprog(input logic s, input logic e, input logic idle);
    repeat (4) @(negedge clk);
    req_std = s; req_ext = e; banks_idle = idle;
    run(14, 1'b0);
    banks_idle = 1'b1;
    chk(!done_dropped, "R11 done", done_dropped, 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    pulse_k = -10;
    // table of configurations walked through full initialization
    for (int v = 0; v < 4; v++) begin
      set_cfg(VEC[v]);
      do_init();
      verify_seq(VEC[v][13:7], VEC[v][6:0]);
    end

    // R8: standard-only reprogram picks up new configuration
    set_cfg(VEC[2]);
    reprog(1'b1, 1'b0, 1'b1);
    chk(n_ev == 1 && ev_t[0] == 3, "R8 std kind", ev_t[0], 3);
    chk(ev_k[0] == 2, "R8 std time", ev_k[0], 2);
    chk(ev_a[0] == {{(AW - 7){1'b0}}, VEC[2][13:7]}, "R8 std word", ev_a[0], VEC[2][13:7]);
    chk(busy_at2 == 1, "R8 busy", busy_at2, 1);

    // R8: extended-only reprogram
    set_cfg(VEC[1]);
    reprog(1'b0, 1'b1, 1'b1);
    chk(n_ev == 1 && ev_t[0] == 4, "R8 ext kind", ev_t[0], 4);
    chk(ev_a[0] == {{(AW - 7){1'b0}}, VEC[1][6:0]}, "R8 ext word", ev_a[0], VEC[1][6:0]);

    // R9: both together, standard first
    reprog(1'b1, 1'b1, 1'b1);
    chk(n_ev == 2, "R9 count", n_ev, 2);
    chk(ev_t[0] == 3 && ev_k[0] == 2, "R9 first", ev_t[0], 3);
    chk(ev_t[1] == 4 && ev_k[1] == 2 + TMR, "R9 second", ev_k[1], 2 + TMR);

    // R10: banks busy, request dropped
    reprog(1'b1, 1'b1, 1'b0);
    chk(n_ev == 0, "R10 banks", n_ev, 0);
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R10 busy", busy, 0);

    // R10: request during power-up wait leaves the sequence intact
    set_cfg(VEC[3]);
    pulse_k = 5;
    do_init();
    pulse_k = -10;
    verify_seq(VEC[3][13:7], VEC[3][6:0]);
    run(12, 1'b0);
    chk(n_ev == 0, "R10 early", n_ev, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule